// File: doc/BRIEF.md
# Syndrome Line Cache with RouteID Partitioning

This block is a small fully associative cache for lines of error-correction syndrome bytes that sit beside protected memory data. Each lookup carries a line tag, a requester RouteID and a read/write flag. A lookup that matches a valid line is answered from the cache. A read that misses fetches the line through a request/response handshake on a backing port, installs it and returns it. A write that misses is filled the same way only when write allocation is switched on.

Replacement is partitioned. Software can dedicate individual lines to one RouteID by writing a line index and then a reservation value. A missing requester replaces only lines that are dedicated to its RouteID, or lines in the shared unreserved pool when it owns none. A single round-robin pointer rotates through the allowed set. Hits are not limited this way: any valid line can serve any requester. An invalidate-all input drops every cached line and leaves the reservations as they are.

Top module: `syndrome_cache`

## Requirements
- R1: After reset no line is valid, every line is unreserved, the line index register is 0, `cfg_val_rdata` reads 0, `req_ready` is 1, and `resp_valid` and `fill_req_valid` are 0.
- R2: A lookup that is accepted (`req_valid` and `req_ready`) and whose tag matches a valid line raises `resp_valid` with `resp_hit`=1 and that line's data in the next cycle. This holds whatever the line's reservation and the requester's RouteID. At most one line matches a tag.
- R3: An accepted read that misses raises `fill_req_valid` with `fill_req_tag` equal to the lookup tag in the next cycle. Both stay unchanged until a cycle with `fill_rsp_valid`=1. In the cycle after that, `resp_valid`=1, `resp_hit`=0 and `resp_data` equals the returned data, and the line is installed when a victim exists.
- R4: While a fill is outstanding (`fill_req_valid`=1), `req_ready` is 0 and no new lookup is taken.
- R5: An accepted write lookup that misses while `wr_alloc_en`=0 responds in the next cycle with `resp_hit`=0 and `resp_data`=0. It issues no fill and installs nothing. With `wr_alloc_en`=1 it behaves as a read miss.
- R6: A pulse on `cfg_idx_we` loads the line index from `cfg_idx_wdata`. A later pulse on `cfg_val_we` writes `cfg_val_wdata` into the reservation of the indexed line. In that value, bit RID_W is the reserve flag and bits RID_W-1:0 are the RouteID. `cfg_val_rdata` always shows the reservation of the indexed line in the same format.
- R7: When at least one line is reserved for the requester's RouteID, a miss replaces only one of those lines.
- R8: When no line is reserved for the requester's RouteID, a miss replaces only an unreserved line.
- R9: The victim is the first line of the allowed set found when searching upward from the round-robin pointer and wrapping past the last line. The pointer then moves to the victim index plus one, modulo the line count. A miss with no victim leaves the pointer unchanged.
- R10: When the allowed set is empty, the miss still runs the fill and returns the data with `resp_hit`=0, but nothing is installed.
- R11: `inv_all` clears every valid bit in the cycle it is high and holds `req_ready` at 0 during that cycle. Reservations are kept. A fill that completes in the same cycle still installs its line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request |
| req_ready | output | 1 | Lookup accepted this cycle when high |
| req_tag | input | TAG_W | Line tag of the lookup |
| req_rid | input | RID_W | Requester RouteID |
| req_write | input | 1 | Lookup comes from a write |
| wr_alloc_en | input | 1 | Allow allocation on write misses |
| resp_valid | output | 1 | Response strobe |
| resp_hit | output | 1 | Response was a hit |
| resp_data | output | LINE_BYTES*8 | Line data of the response |
| fill_req_valid | output | 1 | Fill request to the backing port |
| fill_req_tag | output | TAG_W | Tag being fetched |
| fill_rsp_valid | input | 1 | Fill data returned |
| fill_rsp_data | input | LINE_BYTES*8 | Returned line |
| cfg_idx_we | input | 1 | Write line index register |
| cfg_idx_wdata | input | log2(NUM_LINES) | New line index |
| cfg_val_we | input | 1 | Write reservation of indexed line |
| cfg_val_wdata | input | RID_W+1 | {reserve flag, RouteID} |
| cfg_val_rdata | output | RID_W+1 | Reservation of indexed line |
| inv_all | input | 1 | Invalidate every line |

## Verification
The bench aims at the round-robin search as it wraps past the last line while only some lines are allowed. A design that searched from line 0, or moved the pointer on a victim-less miss, would evict the wrong tag, and a later lookup would miss where a hit is expected. It reserves every line for one RouteID so that another requester has no victim. A design that installed anyway would evict a reserved line, which a following hit check exposes. It also sends write misses with allocation off, where a wrong design would start a fill or install the tag. After an invalidate it reads back reservations to catch a design that cleared them along with the valid bits.

// File: rtl/sc_pkg.sv
package sc_pkg;

    typedef enum logic {
        SC_IDLE = 1'b0,
        SC_FILL = 1'b1
    } sc_state_e;

endpackage

// File: rtl/sc_tag_match.sv
module sc_tag_match #(
    parameter int NUM_LINES = 128,
    parameter int TAG_W     = 26,
    localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic [NUM_LINES-1:0]            line_valid,
    input  logic [NUM_LINES-1:0][TAG_W-1:0] line_tag,
    input  logic [TAG_W-1:0]                look_tag,
    output logic [NUM_LINES-1:0]            match_vec,
    output logic                            match_any,
    output logic [IDX_W-1:0]                match_idx
);

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_cmp
        assign match_vec[g] = line_valid[g] && (line_tag[g] == look_tag);
    end

    assign match_any = |match_vec;

    always_comb begin
        match_idx = '0;
        for (int k = 0; k < NUM_LINES; k++) begin
            if (match_vec[k]) begin
                match_idx = IDX_W'(k);
            end
        end
    end

endmodule

// File: rtl/sc_victim_pick.sv
module sc_victim_pick #(
    parameter int NUM_LINES = 128,
    parameter int RID_W     = 8,
    localparam int IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic [NUM_LINES-1:0]            resv_en,
    input  logic [NUM_LINES-1:0][RID_W-1:0] resv_rid,
    input  logic [RID_W-1:0]                rid,
    input  logic [IDX_W-1:0]                ptr,
    output logic                            found,
    output logic [IDX_W-1:0]                victim
);

    logic [NUM_LINES-1:0] own_vec;
    logic [NUM_LINES-1:0] cand_vec;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_own
        assign own_vec[g] = resv_en[g] && (resv_rid[g] == rid);
    end

    assign cand_vec = (|own_vec) ? own_vec : ~resv_en;

    always_comb begin
        found  = 1'b0;
        victim = '0;
        for (int k = 0; k < NUM_LINES; k++) begin
            int j;
            j = (int'(ptr) + k) % NUM_LINES;
            if (!found && cand_vec[j]) begin
                found  = 1'b1;
                victim = IDX_W'(j);
            end
        end
    end

endmodule

// File: rtl/syndrome_cache.sv
module syndrome_cache
    import sc_pkg::*;
#(
    parameter int NUM_LINES  = 128,
    parameter int LINE_BYTES = 64,
    parameter int TAG_W      = 26,
    parameter int RID_W      = 8,
    localparam int IDX_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
    localparam int LINE_W    = LINE_BYTES * 8,
    localparam int RSV_W     = RID_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic [RID_W-1:0]  req_rid,
    input  logic              req_write,
    input  logic              wr_alloc_en,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic [LINE_W-1:0] resp_data,
    output logic              fill_req_valid,
    output logic [TAG_W-1:0]  fill_req_tag,
    input  logic              fill_rsp_valid,
    input  logic [LINE_W-1:0] fill_rsp_data,
    input  logic              cfg_idx_we,
    input  logic [IDX_W-1:0]  cfg_idx_wdata,
    input  logic              cfg_val_we,
    input  logic [RSV_W-1:0]  cfg_val_wdata,
    output logic [RSV_W-1:0]  cfg_val_rdata,
    input  logic              inv_all
);

    typedef struct packed {
        sc_state_e                       st;
        logic [NUM_LINES-1:0]            valid;
        logic [NUM_LINES-1:0][TAG_W-1:0] tag;
        logic [NUM_LINES-1:0]            resv_en;
        logic [NUM_LINES-1:0][RID_W-1:0] resv_rid;
        logic [IDX_W-1:0]                rr_ptr;
        logic [IDX_W-1:0]                cfg_idx;
        logic [TAG_W-1:0]                pend_tag;
        logic [IDX_W-1:0]                pend_victim;
        logic                            pend_alloc;
        logic                            resp_valid;
        logic                            resp_hit;
        logic [LINE_W-1:0]               resp_data;
    } sc_regs_t;

    sc_regs_t s_d, s_q;
    logic [LINE_W-1:0] dat_d [NUM_LINES];
    logic [LINE_W-1:0] dat_q [NUM_LINES];

    logic [NUM_LINES-1:0] hit_vec;
    logic [NUM_LINES-1:0] line_valid;
    logic                 hit_any;
    logic [IDX_W-1:0]     hit_idx;
    logic                 vic_found;
    logic [IDX_W-1:0]     vic_idx;
    logic                 accept;

    sc_tag_match #(
        .NUM_LINES (NUM_LINES),
        .TAG_W     (TAG_W)
    ) u_match (
        .line_valid (s_q.valid),
        .line_tag   (s_q.tag),
        .look_tag   (req_tag),
        .match_vec  (hit_vec),
        .match_any  (hit_any),
        .match_idx  (hit_idx)
    );

    sc_victim_pick #(
        .NUM_LINES (NUM_LINES),
        .RID_W     (RID_W)
    ) u_victim (
        .resv_en  (s_q.resv_en),
        .resv_rid (s_q.resv_rid),
        .rid      (req_rid),
        .ptr      (s_q.rr_ptr),
        .found    (vic_found),
        .victim   (vic_idx)
    );

    assign line_valid     = s_q.valid;
    assign req_ready      = (s_q.st == SC_IDLE) && !inv_all;
    assign accept         = req_valid && req_ready;
    assign fill_req_valid = (s_q.st == SC_FILL);
    assign fill_req_tag   = s_q.pend_tag;
    assign resp_valid     = s_q.resp_valid;
    assign resp_hit       = s_q.resp_hit;
    assign resp_data      = s_q.resp_data;
    assign cfg_val_rdata  = {s_q.resv_en[s_q.cfg_idx], s_q.resv_rid[s_q.cfg_idx]};

    always_comb begin
        s_d = s_q;
        dat_d = dat_q;
        s_d.resp_valid = 1'b0;
        s_d.resp_hit   = 1'b0;
        s_d.resp_data  = '0;

        // reservation register pair: value write uses the index held so far
        if (cfg_idx_we) begin
            s_d.cfg_idx = cfg_idx_wdata;
        end
        if (cfg_val_we) begin
            s_d.resv_en[s_q.cfg_idx]  = cfg_val_wdata[RID_W];
            s_d.resv_rid[s_q.cfg_idx] = cfg_val_wdata[RID_W-1:0];
        end

        // invalidate first, so a fill ending in this cycle still lands
        if (inv_all) begin
            s_d.valid = '0;
        end

        unique case (s_q.st)
            SC_IDLE: begin
                if (accept) begin
                    if (hit_any) begin
                        s_d.resp_valid = 1'b1;
                        s_d.resp_hit   = 1'b1;
                        s_d.resp_data  = dat_q[hit_idx];
                    end else if (req_write && !wr_alloc_en) begin
                        s_d.resp_valid = 1'b1;
                    end else begin
                        s_d.st          = SC_FILL;
                        s_d.pend_tag    = req_tag;
                        s_d.pend_alloc  = vic_found;
                        s_d.pend_victim = vic_idx;
                        if (vic_found) begin
                            s_d.rr_ptr = IDX_W'((int'(vic_idx) + 1) % NUM_LINES);
                        end
                    end
                end
            end
            SC_FILL: begin
                if (fill_rsp_valid) begin
                    s_d.st         = SC_IDLE;
                    s_d.resp_valid = 1'b1;
                    s_d.resp_data  = fill_rsp_data;
                    if (s_q.pend_alloc) begin
                        s_d.valid[s_q.pend_victim] = 1'b1;
                        s_d.tag[s_q.pend_victim]   = s_q.pend_tag;
                        dat_d[s_q.pend_victim]     = fill_rsp_data;
                    end
                end
            end
            default: s_d.st = SC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_ff @(posedge clk) begin
        dat_q <= dat_d;
    end

endmodule

// File: rtl/syndrome_cache_chk.sv
module syndrome_cache_chk #(
    parameter int NUM_LINES = 128,
    parameter int TAG_W     = 26,
    parameter int RID_W     = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 req_ready,
    input logic                 req_write,
    input logic                 wr_alloc_en,
    input logic                 resp_valid,
    input logic                 resp_hit,
    input logic                 fill_req_valid,
    input logic [TAG_W-1:0]     fill_req_tag,
    input logic                 fill_rsp_valid,
    input logic                 cfg_idx_we,
    input logic                 cfg_val_we,
    input logic [RID_W:0]       cfg_val_wdata,
    input logic [RID_W:0]       cfg_val_rdata,
    input logic                 inv_all,
    input logic [NUM_LINES-1:0] hit_vec,
    input logic [NUM_LINES-1:0] line_valid
);

    logic took;
    assign took = req_valid && req_ready;

    assert_one_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    assert_hit_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        took && (|hit_vec) |=> resp_valid && resp_hit);

    assert_miss_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
        took && !(|hit_vec) && !(req_write && !wr_alloc_en) |=> fill_req_valid && !resp_valid);

    assert_fill_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req_valid && !fill_rsp_valid |=> fill_req_valid && $stable(fill_req_tag));

    assert_fill_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req_valid && fill_rsp_valid |=> resp_valid && !resp_hit && !fill_req_valid);

    assert_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fill_req_valid |-> !req_ready);

    assert_wr_noalloc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        took && !(|hit_vec) && req_write && !wr_alloc_en |=> resp_valid && !resp_hit && !fill_req_valid);

    assert_cfg_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_val_we && !cfg_idx_we |=> cfg_val_rdata == $past(cfg_val_wdata));

    assert_inv_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all && !(fill_req_valid && fill_rsp_valid) |=> $countones(line_valid) == 0);

    assert_inv_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
        inv_all |-> !req_ready);

endmodule

bind syndrome_cache syndrome_cache_chk #(
    .NUM_LINES (NUM_LINES),
    .TAG_W     (TAG_W),
    .RID_W     (RID_W)
) u_chk (.*);

// File: tb/test_syndrome_cache.sv
`timescale 1ns/1ps
module test_syndrome_cache;

    localparam int N      = 8;
    localparam int LB     = 64;
    localparam int TW     = 12;
    localparam int RW     = 4;
    localparam int IW     = $clog2(N);
    localparam int LW     = LB * 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [TW-1:0] req_tag = '0;
    logic [RW-1:0] req_rid = '0;
    logic          req_write = 1'b0;
    logic          wr_alloc_en = 1'b0;
    logic          resp_valid;
    logic          resp_hit;
    logic [LW-1:0] resp_data;
    logic          fill_req_valid;
    logic [TW-1:0] fill_req_tag;
    logic          fill_rsp_valid = 1'b0;
    logic [LW-1:0] fill_rsp_data = '0;
    logic          cfg_idx_we = 1'b0;
    logic [IW-1:0] cfg_idx_wdata = '0;
    logic          cfg_val_we = 1'b0;
    logic [RW:0]   cfg_val_wdata = '0;
    logic [RW:0]   cfg_val_rdata;
    logic          inv_all = 1'b0;

    always #2.5 clk = ~clk;

    syndrome_cache #(
        .NUM_LINES (N), .LINE_BYTES (LB), .TAG_W (TW), .RID_W (RW)
    ) i_syndrome_cache (.*);

    int n_cmp = 0;
    int n_bad = 0;
    int seq   = 0;
    int cycles = 0;

    // reference state
    bit            m_valid [N];
    logic [TW-1:0] m_tag   [N];
    logic [LW-1:0] m_data  [N];
    bit            m_ren   [N];
    logic [RW-1:0] m_rid   [N];
    int            m_ptr = 0;
    int            m_idx = 0;

    task automatic chk(input bit ok, input string rq, input logic [LW-1:0] act, input logic [LW-1:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    function automatic logic [LW-1:0] make_line(input logic [TW-1:0] t, input int s);
        logic [LW-1:0] r;
        for (int w = 0; w < LW/32; w++) begin
            r[w*32 +: 32] = (32'(t) * 32'h9E3779B1) ^ (32'(s) << 12) ^ 32'(w);
        end
        return r;
    endfunction

    function automatic int m_find(input logic [TW-1:0] t);
        for (int i = 0; i < N; i++) if (m_valid[i] && m_tag[i] == t) return i;
        return -1;
    endfunction

    function automatic int m_victim(input logic [RW-1:0] rid);
        bit own [N];
        bit any_own = 0;
        for (int i = 0; i < N; i++) begin
            own[i] = m_ren[i] && m_rid[i] == rid;
            if (own[i]) any_own = 1;
        end
        for (int k = 0; k < N; k++) begin
            int j = (m_ptr + k) % N;
            if (any_own ? own[j] : !m_ren[j]) return j;
        end
        return -1;
    endfunction

    task automatic lookup(input logic [TW-1:0] t, input logic [RW-1:0] rid, input bit wr,
                          input bit alloc, input int dly, input string rq);
        int h, v;
        logic [LW-1:0] fd;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_tag = t; req_rid = rid; req_write = wr; wr_alloc_en = alloc;
        h = m_find(t);
        @(negedge clk);
        req_valid = 1'b0;
        if (h >= 0) begin
            chk(resp_valid && resp_hit, {rq, " hit flag (R2)"}, LW'({resp_valid, resp_hit}), LW'(2'b11));
            chk(resp_data == m_data[h], {rq, " hit data (R2)"}, resp_data, m_data[h]);
        end else if (wr && !alloc) begin
            chk(resp_valid && !resp_hit && !fill_req_valid, "R5 write miss no fill",
                LW'({resp_valid, resp_hit, fill_req_valid}), LW'(3'b100));
            chk(resp_data == '0, "R5 write miss data", resp_data, '0);
        end else begin
            v = m_victim(rid);
            chk(fill_req_valid && !resp_valid, {rq, " fill start (R3)"},
                LW'({fill_req_valid, resp_valid}), LW'(2'b10));
            chk(fill_req_tag == t, "R3 fill tag", LW'(fill_req_tag), LW'(t));
            for (int d = 0; d < dly; d++) begin
                chk(!req_ready && fill_req_valid, "R4 stall while filling",
                    LW'({req_ready, fill_req_valid}), LW'(2'b01));
                @(negedge clk);
            end
            chk(!req_ready, "R4 stall at fill return", LW'(req_ready), '0);
            fd = make_line(t, seq); seq++;
            fill_rsp_valid = 1'b1; fill_rsp_data = fd;
            @(negedge clk);
            fill_rsp_valid = 1'b0;
            chk(resp_valid && !resp_hit, "R3 miss response", LW'({resp_valid, resp_hit}), LW'(2'b10));
            chk(resp_data == fd, "R3 miss data", resp_data, fd);
            if (v >= 0) begin
                m_valid[v] = 1; m_tag[v] = t; m_data[v] = fd; m_ptr = (v + 1) % N;
            end
        end
    endtask

    task automatic set_resv(input int idx, input bit en, input logic [RW-1:0] rid);
        @(negedge clk);
        cfg_idx_we = 1'b1; cfg_idx_wdata = IW'(idx);
        @(negedge clk);
        cfg_idx_we = 1'b0; cfg_val_we = 1'b1; cfg_val_wdata = {en, rid};
        @(negedge clk);
        cfg_val_we = 1'b0;
        m_idx = idx; m_ren[idx] = en; m_rid[idx] = rid;
        chk(cfg_val_rdata == {en, rid}, "R6 reservation readback", LW'(cfg_val_rdata), LW'({en, rid}));
    endtask

    task automatic read_resv(input int idx);
        @(negedge clk);
        cfg_idx_we = 1'b1; cfg_idx_wdata = IW'(idx);
        @(negedge clk);
        cfg_idx_we = 1'b0; m_idx = idx;
        chk(cfg_val_rdata == {m_ren[idx], m_rid[idx]}, "R11 reservation kept (R6 read)",
            LW'(cfg_val_rdata), LW'({m_ren[idx], m_rid[idx]}));
    endtask

    task automatic do_inv();
        @(negedge clk);
        inv_all = 1'b1;
        #0.5;
        chk(!req_ready, "R11 ready low during invalidate", LW'(req_ready), '0);
        @(negedge clk);
        inv_all = 1'b0;
        for (int i = 0; i < N; i++) m_valid[i] = 0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < N; i++) begin
            m_valid[i] = 0; m_ren[i] = 0; m_rid[i] = '0; m_tag[i] = '0; m_data[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(req_ready && !resp_valid && !fill_req_valid, "R1 reset outputs",
            LW'({req_ready, resp_valid, fill_req_valid}), LW'(3'b100));
        chk(cfg_val_rdata == '0, "R1 reset reservation", LW'(cfg_val_rdata), '0);

        // R3 first miss then R2 hit
        lookup(12'h005, 4'd0, 0, 0, 2, "R3");
        lookup(12'h005, 4'd0, 0, 0, 0, "R2");
        // R7 own reserved lines, R9 wrap
        set_resv(6, 1, 4'd3);
        set_resv(7, 1, 4'd3);
        lookup(12'h009, 4'd3, 0, 0, 1, "R7");
        lookup(12'h009, 4'd0, 0, 0, 0, "R2 other rid");
        lookup(12'h00A, 4'd3, 0, 0, 0, "R7");
        lookup(12'h00B, 4'd3, 0, 0, 0, "R7 R9");
        lookup(12'h009, 4'd3, 0, 0, 0, "R7 evicted");
        lookup(12'h00A, 4'd0, 0, 0, 0, "R8 pool");
        lookup(12'h005, 4'd1, 0, 0, 0, "R8 R9 pool wrap");
        // R5 write misses
        lookup(12'h0C0, 4'd0, 1, 0, 0, "R5");
        lookup(12'h0C0, 4'd0, 0, 0, 1, "R5 not installed");
        lookup(12'h0C1, 4'd0, 1, 1, 0, "R5 alloc");
        lookup(12'h0C1, 4'd2, 1, 0, 0, "R5 write hit");
        // R10 no victim
        for (int i = 0; i < N; i++) set_resv(i, 1, 4'd1);
        lookup(12'h0D0, 4'd2, 0, 0, 1, "R10");
        lookup(12'h0D0, 4'd2, 0, 0, 0, "R10 bypass again");
        lookup(12'h0D1, 4'd1, 0, 0, 0, "R7 all owned");
        lookup(12'h0D1, 4'd2, 0, 0, 0, "R2 any rid");
        for (int i = 0; i < N; i++) set_resv(i, 0, 4'd0);
        set_resv(2, 1, 4'd5);
        // R11 invalidate
        do_inv();
        read_resv(2);
        read_resv(4);
        lookup(12'h0D1, 4'd2, 0, 0, 0, "R11 miss after invalidate");

        // random phase
        for (int it = 0; it < 500; it++) begin
            int sel = $urandom % 100;
            if (sel < 8) begin
                set_resv($urandom % N, ($urandom % 3) != 0, RW'($urandom % 4));
            end else if (sel < 11) begin
                do_inv();
                read_resv($urandom % N);
            end else begin
                lookup(TW'($urandom % 20), RW'($urandom % 4), ($urandom % 5) == 0,
                       $urandom % 2, $urandom % 3, "R2/R3/R7/R8/R9 random");
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule